// File: doc/BRIEF.md
# Bidirectional H-Bridge PWM Generator

This block turns a signed drive request into pulse-width modulated logic for the two legs of an H-bridge. The request is one offset-binary word: its middle code means no drive, codes above the middle drive forward, and codes below drive in reverse. The size of the drive grows by one clock of high time for each step away from the middle. The forward leg output carries the pulse during forward drive and the reverse leg output carries it during reverse drive. The idle leg is always held low.

The counter resolution is chosen at run time as 10, 11 or 12 bits, giving periods of 512, 1024 or 2048 clocks. A 4-bit trim widens every non-zero pulse by up to 15 clocks. Duty, direction, resolution and trim are all captured only at a period boundary, so an update in mid-period never produces a runt or stretched pulse. A run input acts as standby, and a fault input forces both legs off within the same cycle.

Top module: `hbridge_pwm`

## Requirements
- R1: With the in-range code equal to the middle value 2^(N-1), N being the active resolution, both outputs stay low for the whole period, whatever the trim.
- R2: An in-range code c above the middle (and not all ones) drives forward. out_a_o is high for the first c-2^(N-1) clocks of each period, then low for the rest of it, and out_b_o stays low.
- R3: An in-range code c below the middle drives in reverse. out_b_o is high for the first 2^(N-1)-c clocks of each period, and out_a_o stays low, so code 0 gives a constant high.
- R4: The all-ones in-range code gives forward drive at full scale: out_a_o stays high for the whole period.
- R5: res_sel_i 0, 1 and 2 select N = 10, 11 and 12, with periods of 2^(N-1) = 512, 1024 and 2048 clocks. The value 3 behaves as 0. Bits of duty_i at position N and above are ignored.
- R6: A non-zero magnitude is increased by trim_i clocks and saturated at the period length. Zero drive stays zero.
- R7: Changes to duty_i, res_sel_i and trim_i take effect only at the start of the next period. The period in progress completes with its old width and length.
- R8: Out of reset, and at any time run_i is low, both outputs are low in that same cycle. A rising run_i restarts the counter, and the new period begins on the first clock edge that sees run_i high.
- R9: While fault_i is high, both outputs are low in that same cycle. The period counter keeps running, so the pulse resumes in phase once the fault is released.
- R10: out_a_o and out_b_o are never high at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | PWM clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | High to operate, low for standby (outputs off, counter restarted) |
| fault_i | input | 1 | High forces both legs low at once |
| res_sel_i | input | 2 | Resolution select: 0 gives 10 bits, 1 gives 11, 2 gives 12, 3 gives 10 |
| duty_i | input | 12 | Offset-binary drive word; only the low N bits are used |
| trim_i | input | 4 | Extra high clocks added to any non-zero pulse |
| out_a_o | output | 1 | Forward leg drive |
| out_b_o | output | 1 | Reverse leg drive |

## Verification
The bench builds the block with its default parameters: a 10-bit minimum resolution, three resolution steps and a 4-bit trim. With these defaults all three period lengths are reachable, up to 2048 clocks, and a single period still fits easily inside the run. Directed cases cover the following points:
- the middle, neighbouring, all-ones and zero codes;
- trim saturation;
- a reserved resolution select with high duty bits set;
- mid-period changes of duty and of resolution;
- standby and fault in mid-period.

Random periods then mix all four select values, codes across the full 12-bit range, and trims, with each output compared clock by clock against the expected pulse shape.

// File: rtl/hbp_pkg.sv
package hbp_pkg;
  typedef enum logic [1:0] {
    DIR_OFF = 2'd0,
    DIR_FWD = 2'd1,
    DIR_REV = 2'd2
  } dir_e;
endpackage

// File: rtl/hbp_decode.sv
// Offset-binary code -> direction, high time and period length.
module hbp_decode #(
  parameter  int MIN_RES   = 10,
  parameter  int RES_STEPS = 3,
  parameter  int TRIM_W    = 4,
  localparam int MAX_RES   = MIN_RES + RES_STEPS - 1,
  localparam int SEL_W     = $clog2(RES_STEPS + 1)
) (
  input  logic [MAX_RES-1:0] code_i,
  input  logic [SEL_W-1:0]   res_sel_i,
  input  logic [TRIM_W-1:0]  trim_i,
  output hbp_pkg::dir_e      dir_o,
  output logic [MAX_RES-1:0] width_o,
  output logic [MAX_RES-1:0] period_o
);
  import hbp_pkg::*;

  localparam logic [SEL_W-1:0] STEPS_L = SEL_W'(RES_STEPS);

  logic [SEL_W-1:0] sel;
  logic [MAX_RES:0] half, top, c, mag;
  logic [MAX_RES+1:0] sum;

  always_comb begin
    sel  = (res_sel_i < STEPS_L) ? res_sel_i : '0;
    half = (MAX_RES+1)'(1) << (MIN_RES - 1 + int'(sel));
    top  = (half << 1) - 1'b1;
    c    = {1'b0, code_i} & top;
    if (c == half) begin
      dir_o = DIR_OFF;
      mag   = '0;
    end else if (c > half) begin
      dir_o = DIR_FWD;
      mag   = (c == top) ? half : c - half;  // full-scale code saturates
    end else begin
      dir_o = DIR_REV;
      mag   = half - c;
    end
    sum = (mag == '0) ? '0 : {1'b0, mag} + (MAX_RES+2)'(trim_i);
    if (sum > {1'b0, half}) sum = {1'b0, half};
    width_o  = sum[MAX_RES-1:0];
    period_o = half[MAX_RES-1:0];
  end
endmodule

// File: rtl/hbp_timebase.sv
// Period counter with shadow registers loaded only at period start.
module hbp_timebase #(
  parameter int MAX_RES = 12,
  parameter int MIN_RES = 10
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               run_i,
  input  hbp_pkg::dir_e      dir_i,
  input  logic [MAX_RES-1:0] width_i,
  input  logic [MAX_RES-1:0] period_i,
  output hbp_pkg::dir_e      dir_o,
  output logic [MAX_RES-1:0] width_o,
  output logic [MAX_RES-1:0] cnt_o
);
  import hbp_pkg::*;

  localparam logic [MAX_RES-1:0] BASE_PER = MAX_RES'(1) << (MIN_RES - 1);

  logic               run_q;
  logic [MAX_RES-1:0] cnt_q, width_q, per_q;
  dir_e               dir_q;
  logic               wrap;

  assign wrap = (cnt_q == per_q - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q   <= 1'b0;
      cnt_q   <= '0;
      width_q <= '0;
      per_q   <= BASE_PER;
      dir_q   <= DIR_OFF;
    end else begin
      run_q <= run_i;
      if (!run_i) begin
        cnt_q   <= '0;
        width_q <= '0;
        dir_q   <= DIR_OFF;
      end else if (!run_q || wrap) begin
        cnt_q   <= '0;
        width_q <= width_i;
        dir_q   <= dir_i;
        per_q   <= period_i;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign dir_o   = dir_q;
  assign width_o = width_q;
  assign cnt_o   = cnt_q;

  // R7: settings are frozen inside a period
  a_r7_shadow_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != '0) |-> ($stable(width_q) && $stable(dir_q) && $stable(per_q)));
  // R5: counter stays inside the captured period
  a_r5_cnt_in_period: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < per_q);
  // R8: standby restarts the period
  a_r8_standby_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (cnt_q == '0));
endmodule

// File: rtl/hbridge_pwm.sv
module hbridge_pwm #(
  parameter  int MIN_RES   = 10,
  parameter  int RES_STEPS = 3,
  parameter  int TRIM_W    = 4,
  localparam int MAX_RES   = MIN_RES + RES_STEPS - 1,
  localparam int SEL_W     = $clog2(RES_STEPS + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               run_i,
  input  logic               fault_i,
  input  logic [SEL_W-1:0]   res_sel_i,
  input  logic [MAX_RES-1:0] duty_i,
  input  logic [TRIM_W-1:0]  trim_i,
  output logic               out_a_o,
  output logic               out_b_o
);
  import hbp_pkg::*;

  dir_e               dec_dir, cur_dir;
  logic [MAX_RES-1:0] dec_width, dec_per, cur_width, cnt;
  logic [1:0]         leg;

  hbp_decode #(.MIN_RES(MIN_RES), .RES_STEPS(RES_STEPS), .TRIM_W(TRIM_W)) u_dec (
    .code_i   (duty_i),
    .res_sel_i(res_sel_i),
    .trim_i   (trim_i),
    .dir_o    (dec_dir),
    .width_o  (dec_width),
    .period_o (dec_per)
  );

  hbp_timebase #(.MAX_RES(MAX_RES), .MIN_RES(MIN_RES)) u_tb (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (run_i),
    .dir_i   (dec_dir),
    .width_i (dec_width),
    .period_i(dec_per),
    .dir_o   (cur_dir),
    .width_o (cur_width),
    .cnt_o   (cnt)
  );

  // leg 0 = forward (A), leg 1 = reverse (B)
  for (genvar g = 0; g < 2; g++) begin : g_leg
    localparam dir_e LEG_DIR = (g == 0) ? DIR_FWD : DIR_REV;
    assign leg[g] = run_i && !fault_i && (cur_dir == LEG_DIR) && (cnt < cur_width);
  end

  assign out_a_o = leg[0];
  assign out_b_o = leg[1];

  a_r10_never_both: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(out_a_o && out_b_o));
  a_r9_fault_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_i |-> (!out_a_o && !out_b_o));
  a_r8_standby_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |-> (!out_a_o && !out_b_o));
  // R2/R3: a pulse can only start at period start (cnt wraps to zero)
  a_r2_rise_at_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(out_a_o) && !$fell(fault_i) && $stable(run_i)) |-> (cnt == '0));
endmodule

// File: tb/sim_hbridge_pwm.sv
module sim_hbridge_pwm;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run = 1'b0;
  logic        fault = 1'b0;
  logic [1:0]  res = 2'd0;
  logic [11:0] duty = 12'd512;
  logic [3:0]  trim = 4'd0;
  logic        out_a, out_b;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  hbridge_pwm u0 (
    .clk_i(clk), .rst_ni(rst_n), .run_i(run), .fault_i(fault),
    .res_sel_i(res), .duty_i(duty), .trim_i(trim),
    .out_a_o(out_a), .out_b_o(out_b)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // expected width (w), direction (d: 0 off, 1 fwd, 2 rev), period (p)
  function automatic void expect_of(input int code, input int rs, input int tr,
                                    output int w, output int d, output int p);
    int n, half, top, c, m;
    n    = 10 + ((rs < 3) ? rs : 0);
    half = 1 << (n - 1);
    top  = (1 << n) - 1;
    c    = code & top;
    if (c == half) begin d = 0; m = 0; end
    else if (c > half) begin d = 1; m = (c == top) ? half : c - half; end
    else begin d = 2; m = half - c; end
    w = (m == 0) ? 0 : ((m + tr > half) ? half : m + tr);
    p = half;
  endfunction

  task automatic start(input int code, input int rs, input int tr);
    @(negedge clk);
    run = 1'b0; duty = code[11:0]; res = rs[1:0]; trim = tr[3:0];
    @(negedge clk);
    run = 1'b1;
  endtask

  // samples period indices i0..i1-1 and compares each clock
  task automatic meas(input int w, input int d, input int i0, input int i1, input string tag);
    int hi = 0, bad = 0, both = 0;
    for (int i = i0; i < i1; i++) begin
      bit ea, eb;
      @(negedge clk);
      ea = (d == 1) && (i < w);
      eb = (d == 2) && (i < w);
      if (out_a !== ea || out_b !== eb) bad++;
      if (out_a && out_b) both++;
      hi += (d == 2) ? int'(out_b) : ((d == 1) ? int'(out_a) : int'(out_a) + int'(out_b));
    end
    check(bad == 0, {tag, " shape"}, bad, 0);
    check(both == 0, {tag, " R10 both high"}, both, 0);
    begin
      int eh;
      eh = (w > i1) ? i1 : w;
      eh = (d == 0 || eh < i0) ? 0 : eh - i0;
      check(hi == eh, {tag, " high count"}, hi, eh);
    end
  endtask

  task automatic full(input int code, input int rs, input int tr, input string tag);
    int w, d, p;
    expect_of(code, rs, tr, w, d, p);
    start(code, rs, tr);
    meas(w, d, 0, p, tag);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int w, d, p;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check(!out_a && !out_b, "R8 in reset", int'(out_a) + int'(out_b), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(!out_a && !out_b, "R8 after reset, standby", int'(out_a) + int'(out_b), 0);

    // directed codes at 10 bits
    full(512, 0, 0, "R1 middle");
    full(512, 0, 15, "R1 R6 middle with trim");
    full(513, 0, 0, "R2 one step fwd");
    full(1022, 0, 0, "R2 510 fwd");
    full(511, 0, 0, "R3 one step rev");
    full(0, 0, 0, "R3 code zero full rev");
    full(1023, 0, 0, "R4 all ones full fwd");
    // resolutions
    full(1024, 1, 0, "R5 R1 11-bit middle");
    full(1500, 1, 0, "R5 11-bit fwd");
    full(4095, 2, 0, "R5 R4 12-bit full");
    full(100, 2, 0, "R5 12-bit rev");
    full(12'hC00 | 600, 3, 0, "R5 sel3 as 10-bit, high bits ignored");
    full(12'h800 | 300, 0, 0, "R5 high bit ignored at 10 bits");
    // trim
    full(520, 0, 15, "R6 trim adds");
    full(1022, 0, 15, "R6 trim saturates");
    full(500, 0, 7, "R6 trim on reverse");

    // R7: duty change in mid-period
    expect_of(612, 0, 0, w, d, p);
    start(612, 0, 0);
    meas(w, d, 0, 50, "R7 before change");
    duty = 12'd412;
    meas(w, d, 50, p, "R7 old width kept");
    expect_of(412, 0, 0, w, d, p);
    meas(w, d, 0, p, "R7 new width next period");

    // R7: resolution change in mid-period
    expect_of(700, 0, 0, w, d, p);
    start(700, 0, 0);
    meas(w, d, 0, 30, "R7 res before change");
    res = 2'd1;
    meas(w, d, 30, p, "R7 old period kept");
    expect_of(700, 1, 0, w, d, p);
    meas(w, d, 0, p, "R7 R5 new period");

    // R8: standby in mid-period
    start(1023, 0, 0);
    meas(512, 1, 0, 20, "R8 running");
    run = 1'b0;
    #1;
    check(!out_a && !out_b, "R8 standby immediate", int'(out_a) + int'(out_b), 0);
    @(negedge clk);
    check(!out_a && !out_b, "R8 standby held", int'(out_a) + int'(out_b), 0);
    run = 1'b1;
    meas(512, 1, 0, 512, "R8 restart from period start");

    // R9: fault in mid-period
    start(612, 0, 0);
    meas(100, 1, 0, 10, "R9 before fault");
    fault = 1'b1;
    #1;
    check(!out_a && !out_b, "R9 fault immediate", int'(out_a) + int'(out_b), 0);
    meas(0, 0, 10, 20, "R9 during fault");
    fault = 1'b0;
    meas(100, 1, 20, 512, "R9 resumes in phase");
    meas(100, 1, 0, 512, "R9 next period");

    // random periods
    for (int k = 0; k < 24; k++) begin
      int rc, rr, rt;
      rr = $urandom_range(3, 0);
      rt = ($urandom_range(3, 0) == 0) ? 0 : $urandom_range(15, 0);
      case ($urandom_range(5, 0))
        0: rc = (rr == 1) ? 1024 : ((rr == 2) ? 2048 : 512);
        1: rc = 0;
        2: rc = 12'hFFF;
        default: rc = $urandom_range(4095, 0);
      endcase
      full(rc, rr, rt, "R2 R3 R10 random");
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule